// File: doc/BRIEF.md
# Physical memory protection checker

This block decides whether one memory access may proceed. It holds a table of protection entries. Each entry has an 8-bit configuration byte and a 32-bit address word. The checker looks at a 32-bit byte address, an access kind and a machine-mode flag, and returns a single allow bit in the same cycle. Each entry matches through one of four address schemes:

- disabled;
- a range bounded above by its own word and below by the word of the entry before it;
- a single aligned 4-byte word;
- an aligned power-of-two region whose size is encoded in the trailing ones of the word.

When several entries claim the same address, the lowest-numbered one decides. A register-write port loads configuration words (four bytes, four entries) and address words (one entry). That port obeys the lock bits. A locked entry is frozen until reset, and its permissions then bind machine mode too.

Top module: `pmp_checker`

## Requirements
- R1: A configuration write (wr_cfg=1) stores byte j of wr_data (bits 8j+7:8j) into entry (wr_idx with its two low bits cleared) + j. Within a byte: bit 7 lock, bits 4:3 mode, bit 2 execute, bit 1 write, bit 0 read. Bits 6:5 are always stored as zero.
- R2: An entry whose mode is 0 never matches.
- R3: Mode 1 (range) matches when the previous entry's address word ≤ chk_addr[31:2] < this entry's address word. Entry 0 uses zero as its lower bound.
- R4: Mode 2 matches only when chk_addr[31:2] equals the address word.
- R5: Mode 3 matches a region of 2^(k+3) bytes, where k is the count of trailing ones in the address word. The region's base is the address word with its low k+1 bits cleared.
- R6: When several entries match, only the lowest-numbered matching entry determines chk_allow.
- R7: When no entry matches, chk_allow equals chk_mmode.
- R8: chk_type selects the permission bit: 0 selects read, 1 selects write, 2 or 3 selects execute. A matching entry decides a non-machine-mode access by that bit. An unlocked matching entry allows any machine-mode access.
- R9: A matching locked entry decides machine-mode accesses by its permission bit as well.
- R10: Writes to the configuration byte or the address word of a locked entry are ignored.
- R11: While entry i+1 is locked and in mode 1, writes to entry i's address word are ignored.
- R12: After reset, every entry is zero: disabled and unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the table |
| wr_cfg | input | 1 | 1: configuration word write, 0: address word write |
| wr_idx | input | IW | Entry index (configuration writes use its group of four) |
| wr_data | input | 32 | Write data |
| chk_addr | input | 32 | Byte address of the access being checked |
| chk_type | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| chk_mmode | input | 1 | Access is made in machine mode |
| chk_allow | output | 1 | Access permitted |

## Verification
Four properties are checked on every cycle:

- the hardwired-zero configuration bits stay zero;
- a locked entry's configuration byte and address word never change;
- the word below a locked range entry is held;
- with every entry disabled, the result equals the machine-mode flag.

The matching schemes, the priority order among overlapping entries, and the difference between locked and unlocked entries for machine mode are shown only by the bench. It sweeps every word of a small address window, for every access kind and both privilege levels, against an arithmetic model, once before and once after locks are applied.

// File: rtl/pmp_checker.sv
module pmp_checker #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_cfg,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [31:0]   chk_addr,
  input  logic [1:0]    chk_type,
  input  logic          chk_mmode,
  output logic          chk_allow
);
  logic [N-1:0][7:0]  cfg_q;
  logic [N-1:0][31:0] addr_q;
  logic [N-1:0]       hit, perm, tor_guard;
  logic [IW-1:0]      grp;
  logic [31:0]        w;

  assign w   = {2'b00, chk_addr[31:2]};
  assign grp = wr_idx & ~IW'(3);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [31:0] lo, ones, care;
    if (i == 0) begin : g_lo0
      assign lo = '0;
    end else begin : g_lon
      assign lo = addr_q[i-1];
    end
    if (i < N-1) begin : g_grd
      assign tor_guard[i] = cfg_q[i+1][7] && cfg_q[i+1][4:3] == 2'd1;
    end else begin : g_grdl
      assign tor_guard[i] = 1'b0;
    end
    assign ones = addr_q[i] & ~(addr_q[i] + 32'd1);
    assign care = ~{ones[30:0], 1'b1};
    always_comb begin
      case (cfg_q[i][4:3])
        2'd1:    hit[i] = (lo <= w) && (w < addr_q[i]);
        2'd2:    hit[i] = (w == addr_q[i]);
        2'd3:    hit[i] = ((w ^ addr_q[i]) & care) == '0;
        default: hit[i] = 1'b0;
      endcase
    end
    assign perm[i] = chk_type[1] ? cfg_q[i][2] : (chk_type[0] ? cfg_q[i][1] : cfg_q[i][0]);
  end

  always_comb begin
    chk_allow = chk_mmode;
    for (int i = N-1; i >= 0; i--)
      if (hit[i]) chk_allow = (cfg_q[i][7] || !chk_mmode) ? perm[i] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (wr_en) begin
      if (wr_cfg) begin
        for (int j = 0; j < 4; j++)
          if (!cfg_q[grp | IW'(j)][7])
            cfg_q[grp | IW'(j)] <= wr_data[8*j +: 8] & 8'h9F;
      end else if (!cfg_q[wr_idx][7] && !tor_guard[wr_idx]) begin
        addr_q[wr_idx] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int N = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0][7:0]  cfg_q,
  input logic [N-1:0][31:0] addr_q,
  input logic               chk_mmode,
  input logic               chk_allow
);
  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < N; i++) if (cfg_q[i][4:3] != 2'd0) all_off = 1'b0;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_zero_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i][6:5] == 2'b00);
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i][7] |=> $stable(cfg_q[i]));
    p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i][7] |=> $stable(addr_q[i]));
    if (i < N-1) begin : g_tor
      p_tor_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i+1][7] && cfg_q[i+1][4:3] == 2'd1) |=> $stable(addr_q[i]));
    end
  end

  p_nomatch_mmode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> chk_allow == chk_mmode);
endmodule

bind pmp_checker pmp_checker_sva #(.N(N)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .addr_q(addr_q),
  .chk_mmode(chk_mmode), .chk_allow(chk_allow)
);

// File: tb/tb_pmp_checker.sv
module tb_pmp_checker;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0, wr_en = 0, wr_cfg = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0, chk_addr = '0;
  logic [1:0] chk_type = '0;
  logic chk_mmode = 0, chk_allow;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  m_cfg [N];
  logic [31:0] m_addr[N];

  always #4 clk = ~clk;

  pmp_checker #(.N(N)) dut (.*);

  function automatic bit ref_allow(input logic [31:0] a, input int t, input bit m);
    longint unsigned wd = a >> 2;
    for (int i = 0; i < N; i++) begin
      int mode = m_cfg[i][4:3];
      bit match = 0;
      longint unsigned top = m_addr[i];
      longint unsigned bot = (i == 0) ? 0 : m_addr[i-1];
      if (mode == 1) match = (bot <= wd) && (wd < top);
      else if (mode == 2) match = (wd == top);
      else if (mode == 3) begin
        int k = 0;
        longint unsigned sz, base;
        while (k < 32 && m_addr[i][k]) k++;
        sz = 64'd1 << (k + 1);
        base = (top / sz) * sz;
        match = (wd >= base) && (wd < base + sz);
      end
      if (match) begin
        bit p = (t >= 2) ? m_cfg[i][2] : m_cfg[i][t];
        return (m_cfg[i][7] || !m) ? p : 1'b1;
      end
    end
    return m;
  endfunction

  task automatic write(input bit c, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_cfg = c; wr_idx = IW'(idx); wr_data = d;
    if (c) begin
      for (int j = 0; j < 4; j++) begin
        int e = (idx / 4) * 4 + j;
        if (!m_cfg[e][7]) m_cfg[e] = d[8*j +: 8] & 8'h9F;
      end
    end else begin
      bit guard = (idx < N-1) && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'd1;
      if (!m_cfg[idx][7] && !guard) m_addr[idx] = d;
    end
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic sweep(input string tag);
    @(negedge clk);
    for (int wd = 0; wd < 256; wd++)
      for (int t = 0; t < 4; t++)
        for (int m = 0; m < 2; m++) begin
          bit exp;
          chk_addr = (32'(wd) << 2) | 32'(t);
          chk_type = 2'(t); chk_mmode = m[0];
          #1;
          exp = ref_allow(chk_addr, t, m[0]);
          checks++;
          if (chk_allow !== exp) begin
            fails++;
            $display("FAIL %s addr=%h type=%0d m=%0d actual=%b expected=%b",
                     tag, chk_addr, t, m, chk_allow, exp);
          end
        end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R12 R7 reset");
    write(0, 0, 32'h43);
    write(0, 1, 32'h60);
    write(0, 2, 32'h50);
    write(0, 3, 32'h4F);
    write(0, 4, 32'h90);
    write(0, 5, 32'hC0);
    write(1, 0, 32'h1F130C19);
    write(1, 5, 32'h00000B60);
    sweep("R1 R2 R3 R4 R5 R6 R8 modes");
    write(1, 4, 32'h00008B18);
    write(1, 1, 32'h1F130C99);
    write(0, 4, 32'h0);
    write(0, 5, 32'h200);
    write(0, 0, 32'h0);
    write(1, 0, 32'h00000000);
    write(1, 7, 32'h00000000);
    sweep("R9 R10 R11 locks");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule